// File: doc/BRIEF.md
# Receiver Polling Duty-Cycle Sequencer

This block duty-cycles a radio receiver so that it spends most of its time powered down. It steps through a fixed loop: a nap phase in which the receive chain is off, a warm-up phase in which the chain is powered and allowed to settle, and a check phase in which an external bit checker judges the incoming stream. A failed check sends the loop back to the nap phase. Once enough good bits have been seen, the block moves to a receive phase, where it stays until the data path reports the end of the telegram.

The nap length is a 5-bit code multiplied by 1024 base clocks, with an optional stretch bit that multiplies it by eight more. The all-ones code parks the receiver in a permanent nap. A 2-bit rate code sets how many base clocks make one warm-up tick. Configuration writes are staged and take effect when the next nap begins. The one exception is a write made during a permanent nap, which takes effect at once. An external force input wakes the receiver from any nap.

Top module: `rx_poll_sequencer`

## Requirements
- R1: The phase output (0 nap, 1 warm-up, 2 check, 3 receive) only moves nap to warm-up, warm-up to check, check to nap or receive, and receive to nap.
- R2: With the stretch bit clear, a nap lasts nap code × 1024 base clock cycles, counted from the edge that enters the nap; a nap code of 0 gives a nap of one cycle.
- R3: With the stretch bit set, the nap lasts eight times as long (nap code × 8 × 1024 cycles).
- R4: While the applied nap code is 31 (all ones), the block stays in the nap phase until a configuration write or the force input arrives.
- R5: Warm-up lasts warm-up ticks × D base cycles, where D is 8, 4, 2 or 1 for rate code 0, 1, 2 or 3; a tick count of 0 counts as 1.
- R6: A high force input sampled during a nap starts warm-up at the next edge, and the wake strobe is high for exactly the first warm-up cycle.
- R7: A fail pulse in the check phase returns the block to the nap phase at the next edge, whatever the good-bit count, and it wins over a good-bit pulse in the same cycle.
- R8: The block enters the receive phase on the edge that samples the N-th good-bit pulse of the check phase (N is the bit target; 0 counts as 1); fewer pulses leave it checking.
- R9: An end pulse in the receive phase returns the block to the nap phase at the next edge.
- R10: The active output is high exactly when the phase is not nap.
- R11: A write made outside a permanent nap is held and applied when the next nap is entered, and a write sampled on that entry edge is included; the running nap and warm-up keep the old values.
- R12: A write during a permanent nap is applied at once and restarts the nap timer from that edge.
- R13: After reset the block is in the nap phase with active and wake low and the applied nap code at 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the nap code, stretch bit and rate code |
| cfg_nap | input | 5 | Nap length code; 31 selects a permanent nap |
| cfg_stretch | input | 1 | Multiplies the nap length by eight when set |
| cfg_rate | input | 2 | Rate code selecting base cycles per warm-up tick |
| cfg_warm_ticks | input | WARM_W | Warm-up length in ticks, latched when warm-up starts |
| cfg_bit_target | input | NBIT_W | Good bits needed to reach receive, latched when check starts |
| force_on | input | 1 | Wakes the receiver from a nap |
| bit_ok | input | 1 | One pulse per good bit from the bit checker |
| bit_fail | input | 1 | Pulse from the bit checker when no valid signal is found |
| rx_end | input | 1 | Pulse at the end of a received telegram |
| phase | output | 2 | Current phase code |
| rx_active | output | 1 | High when the receiver is out of the nap phase |
| frontend_wake | output | 1 | One-cycle strobe at the start of warm-up |

## Verification
Every pulse input (force, fail, good bit, end, write) shows its effect on the phase one edge after the edge that samples it. A nap ends exactly its length in cycles after the edge that entered it, and a warm-up ends ticks × D cycles after its entry edge. The driver counts edges and, for each stimulus, pushes the phase and wake value expected at the exact cycle index just before and at each boundary. The monitor compares these entries at the falling edge of that cycle, so an early or late transition by one cycle is caught.

// File: rtl/rxpoll_pkg.sv
// Shared types for the receiver polling sequencer.
// Assumes the nap code is 5 bits and the rate code is 2 bits.
package rxpoll_pkg;

    localparam int NAP_W  = 5;
    localparam int RATE_W = 2;

    typedef enum logic [1:0] {
        PH_NAP  = 2'd0,
        PH_WARM = 2'd1,
        PH_CHK  = 2'd2,
        PH_RECV = 2'd3
    } phase_e;

    typedef struct packed {
        logic [NAP_W-1:0]  nap;
        logic              stretch;
        logic [RATE_W-1:0] rate;
    } poll_cfg_t;

endpackage

// File: rtl/rxpoll_cfg_shadow.sv
// Staged and applied copies of the polling configuration.
// A write lands in the staged copy; the applied copy takes the staged
// value (or a write arriving in the same cycle) only when 'arm' is high.
// Assumes the caller raises 'arm' on nap entry and on permanent-nap writes.
module rxpoll_cfg_shadow
    import rxpoll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  poll_cfg_t wr_cfg,
    input  logic      arm,
    output poll_cfg_t next_cfg,
    output poll_cfg_t applied_cfg
);

    localparam poll_cfg_t CFG_RST = '{nap: '1, stretch: 1'b0, rate: '0};

    poll_cfg_t staged_q;
    poll_cfg_t applied_q;

    // Value that would be applied this cycle: a fresh write overrides the staged copy.
    always_comb begin
        next_cfg = wr ? wr_cfg : staged_q;
    end

    // Staged copy follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= CFG_RST;
        end else if (wr) begin
            staged_q <= wr_cfg;
        end
    end

    // Applied copy changes only when armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied_q <= CFG_RST;
        end else if (arm) begin
            applied_q <= next_cfg;
        end
    end

    assign applied_cfg = applied_q;

    AST_APPLIED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> $stable(applied_q)); // R11

endmodule

// File: rtl/rxpoll_prescaler.sv
// Warm-up tick generator: one tick every 2**(DIV_LOG2_MAX - rate) cycles.
// The count restarts on 'clr' so the first tick falls a full period after
// warm-up entry. Assumes 'rate' stays constant while 'run' is high.
module rxpoll_prescaler #(
    parameter int DIV_LOG2_MAX = 3,
    parameter int RATE_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int CW = (DIV_LOG2_MAX > 0) ? DIV_LOG2_MAX : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Terminal count for the selected rate.
    always_comb begin
        int sh;
        sh = DIV_LOG2_MAX - int'(rate);
        if (sh < 0) begin
            sh = 0;
        end
        lim = CW'((1 << sh) - 1);
    end

    assign tick = run && (cnt_q == lim);

    // Free count while running, cleared on wrap or on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= lim); // R5

    AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr && !tick |=> cnt_q == $past(cnt_q) + 1'b1); // R5

endmodule

// File: rtl/rxpoll_nap_timer.sv
// Down counter timing one nap in base clock cycles.
// Loaded with (length - 1) on nap entry; 'expired' is high once it reaches 0.
// Assumes the caller holds 'run' low during a permanent nap.
module rxpoll_nap_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    // Load on entry, otherwise count down to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_NAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !run |=> $stable(cnt_q)); // R4

    AST_NAP_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val)); // R2

endmodule

// File: rtl/rxpoll_phase_fsm.sv
// Phase sequencer: nap -> warm-up -> check -> nap or receive -> nap.
// Holds the warm-up tick counter and the good-bit counter, both latched on
// phase entry. Assumes 'tick' comes from a prescaler cleared on warm-up entry.
module rxpoll_phase_fsm
    import rxpoll_pkg::*;
#(
    parameter int WARM_W = 8,
    parameter int NBIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nap_expired,
    input  logic              nap_perm,
    input  logic              force_on,
    input  logic              tick,
    input  logic [WARM_W-1:0] warm_ticks,
    input  logic [NBIT_W-1:0] bit_target,
    input  logic              bit_ok,
    input  logic              bit_fail,
    input  logic              rx_end,
    output phase_e            phase,
    output logic              enter_nap,
    output logic              enter_warm,
    output logic              wake
);

    phase_e            st_q;
    phase_e            st_d;
    logic [WARM_W-1:0] warm_left_q;
    logic [NBIT_W-1:0] ok_cnt_q;
    logic [NBIT_W-1:0] target_q;
    logic              wake_q;
    logic              enter_chk;
    logic              bits_done;

    assign bits_done = bit_ok && (ok_cnt_q == target_q - 1'b1);

    // Next-phase decision.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_NAP: begin
                if (force_on || (nap_expired && !nap_perm)) begin
                    st_d = PH_WARM;
                end
            end
            PH_WARM: begin
                if (tick && (warm_left_q == WARM_W'(1))) begin
                    st_d = PH_CHK;
                end
            end
            PH_CHK: begin
                if (bit_fail) begin
                    st_d = PH_NAP;
                end else if (bits_done) begin
                    st_d = PH_RECV;
                end
            end
            PH_RECV: begin
                if (rx_end) begin
                    st_d = PH_NAP;
                end
            end
            default: st_d = PH_NAP;
        endcase
    end

    assign enter_nap  = (st_q != PH_NAP) && (st_d == PH_NAP);
    assign enter_warm = (st_q == PH_NAP) && (st_d == PH_WARM);
    assign enter_chk  = (st_q == PH_WARM) && (st_d == PH_CHK);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PH_NAP;
        end else begin
            st_q <= st_d;
        end
    end

    // Warm-up tick counter, loaded with at least one tick on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_left_q <= '0;
        end else if (enter_warm) begin
            warm_left_q <= (warm_ticks == '0) ? WARM_W'(1) : warm_ticks;
        end else if ((st_q == PH_WARM) && tick) begin
            warm_left_q <= warm_left_q - 1'b1;
        end
    end

    // Good-bit counter and target, both captured on check entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_cnt_q <= '0;
            target_q <= NBIT_W'(1);
        end else if (enter_chk) begin
            ok_cnt_q <= '0;
            target_q <= (bit_target == '0) ? NBIT_W'(1) : bit_target;
        end else if ((st_q == PH_CHK) && bit_ok && !bit_fail && !bits_done) begin
            ok_cnt_q <= ok_cnt_q + 1'b1;
        end
    end

    // Wake strobe, high for the first warm-up cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= enter_warm;
        end
    end

    assign phase = st_q;
    assign wake  = wake_q;

    AST_NAP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PH_NAP |=> st_q inside {PH_NAP, PH_WARM}); // R1

    AST_WARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PH_WARM |=> st_q inside {PH_WARM, PH_CHK}); // R1

    AST_FAIL_TO_NAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PH_CHK && bit_fail |=> st_q == PH_NAP); // R7

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q); // R6

    AST_WAKE_IN_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> st_q == PH_WARM); // R6

    AST_RECV_END: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PH_RECV && rx_end |=> st_q == PH_NAP); // R9

    AST_OK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PH_CHK |-> ok_cnt_q < target_q); // R8

endmodule

// File: rtl/rx_poll_sequencer.sv
// Receiver polling duty-cycle sequencer, top level.
// Ties the configuration shadow, nap timer, warm-up prescaler and phase
// sequencer together and computes the nap length in base clock cycles.
// Assumes bit_ok, bit_fail, rx_end and cfg_wr are single-cycle pulses.
module rx_poll_sequencer
    import rxpoll_pkg::*;
#(
    parameter int NAP_UNIT     = 1024,
    parameter int STRETCH_MULT = 8,
    parameter int DIV_LOG2_MAX = 3,
    parameter int WARM_W       = 8,
    parameter int NBIT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [4:0]        cfg_nap,
    input  logic              cfg_stretch,
    input  logic [1:0]        cfg_rate,
    input  logic [WARM_W-1:0] cfg_warm_ticks,
    input  logic [NBIT_W-1:0] cfg_bit_target,
    input  logic              force_on,
    input  logic              bit_ok,
    input  logic              bit_fail,
    input  logic              rx_end,
    output logic [1:0]        phase,
    output logic              rx_active,
    output logic              frontend_wake
);

    localparam int NAP_MAX = ((1 << NAP_W) - 1) * STRETCH_MULT * NAP_UNIT;
    localparam int CNT_W   = $clog2(NAP_MAX + 1);

    poll_cfg_t   wr_cfg;
    poll_cfg_t   next_cfg;
    poll_cfg_t   applied_cfg;
    phase_e      ph;
    logic        enter_nap;
    logic        enter_warm;
    logic        perm_nap;
    logic        arm;
    logic        nap_expired;
    logic        tick;
    logic [CNT_W-1:0] nap_load;

    // Pack the write port into the configuration record.
    always_comb begin
        wr_cfg.nap     = cfg_nap;
        wr_cfg.stretch = cfg_stretch;
        wr_cfg.rate    = cfg_rate;
    end

    assign perm_nap = (ph == PH_NAP) && (applied_cfg.nap == '1);
    assign arm      = enter_nap || (perm_nap && cfg_wr);

    // Nap length minus one for the value about to be applied.
    always_comb begin
        int unsigned len;
        len = int'(next_cfg.nap) * (next_cfg.stretch ? STRETCH_MULT : 1) * NAP_UNIT;
        nap_load = (len == 0) ? '0 : CNT_W'(len - 1);
    end

    rxpoll_cfg_shadow u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (cfg_wr),
        .wr_cfg      (wr_cfg),
        .arm         (arm),
        .next_cfg    (next_cfg),
        .applied_cfg (applied_cfg)
    );

    rxpoll_nap_timer #(
        .CW (CNT_W)
    ) u_nap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (nap_load),
        .run      ((ph == PH_NAP) && !perm_nap),
        .expired  (nap_expired)
    );

    rxpoll_prescaler #(
        .DIV_LOG2_MAX (DIV_LOG2_MAX),
        .RATE_W       (RATE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (enter_warm),
        .run   (ph == PH_WARM),
        .rate  (applied_cfg.rate),
        .tick  (tick)
    );

    rxpoll_phase_fsm #(
        .WARM_W (WARM_W),
        .NBIT_W (NBIT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .nap_expired (nap_expired),
        .nap_perm    (perm_nap),
        .force_on    (force_on),
        .tick        (tick),
        .warm_ticks  (cfg_warm_ticks),
        .bit_target  (cfg_bit_target),
        .bit_ok      (bit_ok),
        .bit_fail    (bit_fail),
        .rx_end      (rx_end),
        .phase       (ph),
        .enter_nap   (enter_nap),
        .enter_warm  (enter_warm),
        .wake        (frontend_wake)
    );

    assign phase     = ph;
    assign rx_active = (ph != PH_NAP);

    AST_PERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        perm_nap && !force_on |=> ph == PH_NAP); // R4

    AST_PERM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        perm_nap && cfg_wr |=> applied_cfg == $past(wr_cfg)); // R12

    AST_FORCE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_NAP && force_on |=> ph == PH_WARM && frontend_wake); // R6

endmodule

// File: tb/rx_poll_sequencer_tb_top.sv
`timescale 1ns/1ps
module rx_poll_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_nap = '0;
    logic       cfg_stretch = 1'b0;
    logic [1:0] cfg_rate = '0;
    logic [7:0] cfg_warm_ticks = 8'd3;
    logic [3:0] cfg_bit_target = 4'd2;
    logic       force_on = 1'b0;
    logic       bit_ok = 1'b0;
    logic       bit_fail = 1'b0;
    logic       rx_end = 1'b0;
    logic [1:0] phase;
    logic       rx_active;
    logic       frontend_wake;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;

    int         q_cyc[$];
    logic [1:0] q_ph[$];
    logic       q_wk[$];
    string      q_tag[$];

    rx_poll_sequencer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr         (cfg_wr),
        .cfg_nap        (cfg_nap),
        .cfg_stretch    (cfg_stretch),
        .cfg_rate       (cfg_rate),
        .cfg_warm_ticks (cfg_warm_ticks),
        .cfg_bit_target (cfg_bit_target),
        .force_on       (force_on),
        .bit_ok         (bit_ok),
        .bit_fail       (bit_fail),
        .rx_end         (rx_end),
        .phase          (phase),
        .rx_active      (rx_active),
        .frontend_wake  (frontend_wake)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue the state expected after edge number c.
    task automatic expect_at(input int c, input logic [1:0] ph, input logic wk, input string tag);
        q_cyc.push_back(c);
        q_ph.push_back(ph);
        q_wk.push_back(wk);
        q_tag.push_back(tag);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [4:0] nap, input logic st, input logic [1:0] rt);
        cfg_nap = nap;
        cfg_stretch = st;
        cfg_rate = rt;
        cfg_wr = 1'b1;
    endtask

    // Monitor: compare queued expectations at their cycle.
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            n_vec++;
            if (q_cyc[0] < cyc) begin
                n_bad++;
                $display("FAIL %s: expectation for cycle %0d checked late at %0d", q_tag[0], q_cyc[0], cyc);
            end else if (phase !== q_ph[0] || frontend_wake !== q_wk[0] ||
                         rx_active !== (q_ph[0] != 2'd0)) begin
                n_bad++;
                $display("FAIL %s (R10 active) at cycle %0d: phase=%0d wake=%0b active=%0b expected phase=%0d wake=%0b active=%0b",
                         q_tag[0], cyc, phase, frontend_wake, rx_active,
                         q_ph[0], q_wk[0], (q_ph[0] != 2'd0));
            end
            void'(q_cyc.pop_front());
            void'(q_ph.pop_front());
            void'(q_wk.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got cycle %0d expected under 100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int k, e, s, f, g, h, p, w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        k = cyc;
        expect_at(k + 1, 2'd0, 1'b0, "R13 reset state");
        expect_at(k + 2000, 2'd0, 1'b0, "R4 permanent nap after reset");
        wait_cyc(k + 2000);

        // R12: write during permanent nap, nap 2, rate 0 (8 cycles per tick).
        k = cyc;
        write_cfg(5'd2, 1'b0, 2'd0);
        @(negedge clk) cfg_wr = 1'b0;
        expect_at(k + 2048, 2'd0, 1'b0, "R12 R2 nap still running");
        expect_at(k + 2049, 2'd1, 1'b1, "R12 R2 nap of 2048 ends");
        expect_at(k + 2050, 2'd1, 1'b0, "R6 wake one cycle");
        e = k + 2049;
        expect_at(e + 23, 2'd1, 1'b0, "R5 warm-up 3 ticks x 8");
        expect_at(e + 24, 2'd2, 1'b0, "R5 R1 check after warm-up");
        wait_cyc(e + 24);
        bit_ok = 1'b1;
        @(negedge clk) bit_ok = 1'b0;
        expect_at(e + 26, 2'd2, 1'b0, "R8 one good bit of two");
        wait_cyc(e + 26);
        bit_ok = 1'b1;
        @(negedge clk) bit_ok = 1'b0;
        expect_at(e + 27, 2'd3, 1'b0, "R8 second good bit enters receive");
        expect_at(e + 30, 2'd3, 1'b0, "R9 receive holds");
        wait_cyc(e + 30);
        rx_end = 1'b1;
        @(negedge clk) rx_end = 1'b0;
        s = e + 31;
        expect_at(s, 2'd0, 1'b0, "R9 end returns to nap");

        // R11: staged write during a running nap.
        wait_cyc(s + 9);
        write_cfg(5'd1, 1'b0, 2'd3);
        @(negedge clk) cfg_wr = 1'b0;
        expect_at(s + 2047, 2'd0, 1'b0, "R11 old nap length kept");
        expect_at(s + 2048, 2'd1, 1'b1, "R11 R1 loop repeats");
        f = s + 2048;
        expect_at(f + 23, 2'd1, 1'b0, "R11 old rate kept");
        expect_at(f + 24, 2'd2, 1'b0, "R11 check after old-rate warm-up");
        wait_cyc(f + 24);
        bit_fail = 1'b1;
        @(negedge clk) bit_fail = 1'b0;
        expect_at(f + 25, 2'd0, 1'b0, "R7 fail returns to nap");
        g = f + 25 + 1024;
        expect_at(g - 1, 2'd0, 1'b0, "R2 nap of 1024 running");
        expect_at(g, 2'd1, 1'b1, "R2 nap of 1024 ends");
        expect_at(g + 2, 2'd1, 1'b0, "R5 rate 3 warm-up");
        expect_at(g + 3, 2'd2, 1'b0, "R5 rate 3 gives 3 cycles");

        // R3: stretch, written on the nap entry edge together with a fail.
        wait_cyc(g + 3);
        write_cfg(5'd1, 1'b1, 2'd1);
        bit_fail = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        bit_fail = 1'b0;
        expect_at(g + 4, 2'd0, 1'b0, "R7 fail with write");
        h = g + 4 + 8192;
        expect_at(h - 1, 2'd0, 1'b0, "R3 R11 stretched nap running");
        expect_at(h, 2'd1, 1'b1, "R3 stretched nap of 8192 ends");
        expect_at(h + 11, 2'd1, 1'b0, "R5 rate 1 warm-up");
        expect_at(h + 12, 2'd2, 1'b0, "R5 rate 1 gives 12 cycles");
        wait_cyc(h + 12);
        bit_ok = 1'b1;
        @(negedge clk) bit_ok = 1'b0;
        wait_cyc(h + 14);
        bit_fail = 1'b1;
        bit_ok = 1'b1;
        @(negedge clk);
        bit_fail = 1'b0;
        bit_ok = 1'b0;
        expect_at(h + 15, 2'd0, 1'b0, "R7 fail wins over final good bit");

        // R6: force during a running nap.
        wait_cyc(h + 100);
        force_on = 1'b1;
        @(negedge clk) force_on = 1'b0;
        expect_at(h + 101, 2'd1, 1'b1, "R6 force wakes from nap");
        expect_at(h + 113, 2'd2, 1'b0, "R6 check after forced warm-up");
        wait_cyc(h + 113);
        write_cfg(5'd31, 1'b1, 2'd1);
        bit_fail = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        bit_fail = 1'b0;
        p = h + 114;
        expect_at(p, 2'd0, 1'b0, "R7 R11 nap entry with code 31");
        expect_at(p + 3000, 2'd0, 1'b0, "R4 code 31 holds nap");
        wait_cyc(p + 3000);
        force_on = 1'b1;
        @(negedge clk) force_on = 1'b0;
        expect_at(p + 3001, 2'd1, 1'b1, "R4 R6 force leaves permanent nap");
        expect_at(p + 3013, 2'd2, 1'b0, "R5 check after forced warm-up");
        wait_cyc(p + 3013);
        bit_fail = 1'b1;
        @(negedge clk) bit_fail = 1'b0;
        expect_at(p + 3014, 2'd0, 1'b0, "R7 back to nap");
        expect_at(p + 3514, 2'd0, 1'b0, "R4 permanent nap again");
        wait_cyc(p + 3514);

        // R12 and R2: code 0 written in permanent nap gives a one-cycle nap.
        w = cyc;
        write_cfg(5'd0, 1'b0, 2'd3);
        @(negedge clk) cfg_wr = 1'b0;
        expect_at(w + 1, 2'd0, 1'b0, "R12 write applied, still napping");
        expect_at(w + 2, 2'd1, 1'b1, "R12 R2 code 0 one-cycle nap");
        expect_at(w + 5, 2'd2, 1'b0, "R5 rate 3 after immediate write");
        wait_cyc(w + 8);

        while (q_cyc.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule